// File: doc/BRIEF.md
# Prescaled Two-Channel Pulse-Width Modulator

This block generates pulse-width modulated outputs on up to two identical channels. Each channel divides the input clock by a programmable prescale factor to form a counter tick. A period counter then runs through one waveform period, and the output is active for the first part of each period. Software sets up a channel through three registers on a simple synchronous write/read bus: a control word (prescale and stop mode), a duty word (on-time and a full-on flag) and a period word. A per-channel enable input starts and stops the waveform.

Register writes land in shadow copies. A running channel takes them over only at the end of its current period, so a waveform never shows a half-updated period. An idle channel takes them over at once. When the enable drops, the control word's stop-mode bit picks the behaviour. The channel either halts on the next clock, or it finishes the period in progress before it goes quiet.

Top module: `prescaled_pwm`

## Requirements
- R1: Channel c owns byte offsets 16*c + 0x0 (control), 16*c + 0x4 (duty) and 16*c + 0x8 (period). An access hits a register only when addr[1:0] is 0.
- R2: A read returns the shadow value last written, with unused bits read as zero: control bits [6:0], duty bits [10:0], period bits [9:0]. Writes to undefined offsets (addr[3:2]==3, addr[1:0]!=0, or a channel index with no channel) change nothing, and reads there return 0.
- R3: Control bits [5:0] hold the prescale P and period bits [9:0] hold PV. One period lasts (P+1)*(PV+1) clocks.
- R4: Duty bits [9:0] hold DC. Counting from the first clock after the edge that samples the enable high, the output is active for the first (P+1)*DC clocks of every period.
- R5: With DC = 0 and the full flag clear, the output stays inactive for the whole period.
- R6: With DC >= PV+1, the output is active for the whole period.
- R7: Duty bit 10 is a full-on flag. When it is set, the output is active for the whole period whatever DC holds.
- R8: With control bit 6 set, the clock edge that samples the enable low stops the channel, and the output is inactive from then on.
- R9: With control bit 6 clear, a dropped enable lets the current period run to its end. The output then goes inactive and the counters halt.
- R10: While a channel runs, a new register value takes effect at the next period boundary. While it is idle, a new value takes effect at once.
- R11: After reset, every output is inactive and every register reads zero.
- R12: The channels are independent. Running one channel leaves the other's output and registers untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W (5) | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| chanEn | input | NUM_CH (2) | Per-channel run enable |
| pwmOut | output | NUM_CH (2) | Per-channel waveform, active high |

## Verification
The assertions assume that the enable, address and write inputs change only between clock edges and are stable at the sampling edge. They also assume the enable may rise or fall in any cycle, including the very cycle of a period boundary. The stop properties depend on the active stop-mode copy holding still while a channel drains. The directed stimulus changes every input at the falling clock edge, and it reprograms a channel only while that channel is idle or, in the shadow test, in the middle of a period.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  localparam int PRE_W  = 6;
  localparam int CNT_W  = 10;
  localparam int DATA_W = 32;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_DUTY = 2'd1;
  localparam logic [1:0] REG_PER  = 2'd2;

  // one channel's programmable settings (shadow and active copies)
  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             abrupt;
    logic [CNT_W-1:0] dc;
    logic             full;
    logic [CNT_W-1:0] pv;
  } chanCfg_t;

  // strobes from control to a channel datapath
  typedef struct packed {
    logic clear;  // hold counters at zero
    logic count;  // channel running: advance counters
    logic load;   // copy shadow settings into the active set
  } chanStb_t;
endpackage

// File: rtl/pwmc_ctrl.sv
module pwmc_ctrl
  import pwmc_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic [NUM_CH-1:0] bound,
  input  logic [NUM_CH-1:0] actAbrupt,
  output chanCfg_t          cfgSh [NUM_CH],
  output chanStb_t          stb   [NUM_CH],
  output logic [NUM_CH-1:0] run
);
  localparam int SEL_W = ADDR_W - 4;

  logic [SEL_W-1:0] chSel;
  logic [1:0]       regSel;
  logic             wordOk;

  assign chSel  = addr[ADDR_W-1:4];
  assign regSel = addr[3:2];
  assign wordOk = (addr[1:0] == 2'b00) && (int'(chSel) < NUM_CH) && (regSel != 2'd3);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hitC;
    assign hitC = wrEn && wordOk && (int'(chSel) == c);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgSh[c] <= '0;
      end else if (hitC) begin
        case (regSel)
          REG_CTRL: begin
            cfgSh[c].pre    <= wdata[PRE_W-1:0];
            cfgSh[c].abrupt <= wdata[PRE_W];
          end
          REG_DUTY: begin
            cfgSh[c].dc   <= wdata[CNT_W-1:0];
            cfgSh[c].full <= wdata[CNT_W];
          end
          REG_PER: cfgSh[c].pv <= wdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end

    // running channel keeps going on a low enable until its stop condition
    always_ff @(posedge clk) begin
      if (!rstN)       run[c] <= 1'b0;
      else if (run[c]) run[c] <= chanEn[c] || !(actAbrupt[c] || bound[c]);
      else             run[c] <= chanEn[c];
    end

    assign stb[c].count = run[c];
    assign stb[c].clear = !run[c];
    assign stb[c].load  = !run[c] || bound[c];
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (wordOk && int'(chSel) == c) begin
        case (regSel)
          REG_CTRL: rdata[PRE_W:0] = {cfgSh[c].abrupt, cfgSh[c].pre};
          REG_DUTY: rdata[CNT_W:0] = {cfgSh[c].full, cfgSh[c].dc};
          REG_PER:  rdata[CNT_W-1:0] = cfgSh[c].pv;
          default:  rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwmc_chan.sv
module pwmc_chan
  import pwmc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  chanStb_t stb,
  input  chanCfg_t cfgSh,
  output logic     pwmOut,
  output logic     bound,
  output logic     actAbrupt
);
  chanCfg_t         act;
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] perCnt;
  logic             tick;

  assign tick      = (preCnt == act.pre);
  assign bound     = stb.count && tick && (perCnt == act.pv);
  assign actAbrupt = act.abrupt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      act <= '0;
    end else if (stb.load) begin
      act <= cfgSh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      preCnt <= '0;
      perCnt <= '0;
    end else if (stb.count) begin
      if (tick) begin
        preCnt <= '0;
        perCnt <= (perCnt == act.pv) ? '0 : perCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign pwmOut = stb.count && (act.full || (perCnt < act.dc));
endmodule

// File: rtl/prescaled_pwm.sv
module prescaled_pwm
  import pwmc_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NUM_CH-1:0] chanEn,
  output logic [NUM_CH-1:0] pwmOut
);
  chanCfg_t          cfgSh [NUM_CH];
  chanStb_t          stb   [NUM_CH];
  logic [NUM_CH-1:0] chRun;
  logic [NUM_CH-1:0] chBound;
  logic [NUM_CH-1:0] actAbrupt;

  pwmc_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .chanEn(chanEn), .bound(chBound), .actAbrupt(actAbrupt),
    .cfgSh(cfgSh), .stb(stb), .run(chRun)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dp
    pwmc_chan u_chan (
      .clk(clk), .rstN(rstN), .stb(stb[c]), .cfgSh(cfgSh[c]),
      .pwmOut(pwmOut[c]), .bound(chBound[c]), .actAbrupt(actAbrupt[c])
    );
  end
endmodule

// File: rtl/pwmc_chk.sv
module pwmc_chk #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic [NUM_CH-1:0] chanEn,
  input logic [NUM_CH-1:0] pwmOut,
  input logic [NUM_CH-1:0] chRun,
  input logic [NUM_CH-1:0] chBound,
  input logic [NUM_CH-1:0] actAbrupt
);
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr[3:2] == 2'd3) |-> (rdata == 32'd0)); // R2

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      !chRun[c] |-> !pwmOut[c]); // R11
    AST_START_RUN: assert property (@(posedge clk) disable iff (!rstN)
      (!chRun[c] && chanEn[c]) |=> chRun[c]); // R4
    AST_ABRUPT_HALT: assert property (@(posedge clk) disable iff (!rstN)
      (chRun[c] && !chanEn[c] && actAbrupt[c]) |=> !chRun[c]); // R8
    AST_GRACE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (chRun[c] && !chanEn[c] && !actAbrupt[c] && !chBound[c]) |=> chRun[c]); // R9
    AST_GRACE_END: assert property (@(posedge clk) disable iff (!rstN)
      (chRun[c] && !chanEn[c] && chBound[c]) |=> !chRun[c]); // R9
  end
endmodule

bind prescaled_pwm pwmc_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .rdata(rdata), .chanEn(chanEn),
  .pwmOut(pwmOut), .chRun(chRun), .chBound(chBound), .actAbrupt(actAbrupt)
);

// File: tb/tb_prescaled_pwm.sv
`timescale 1ns/1ps
module tb_prescaled_pwm;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  chanEn = '0;
  logic [1:0]  pwmOut;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  prescaled_pwm dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .chanEn(chanEn), .pwmOut(pwmOut)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a falling edge, returns at a falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(pwmOut == 2'b00, "R11 outputs", int'(pwmOut), 0);
    foreach (d[i]) ; // no-op to keep loop style uniform
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), d);
      chk(d == 0, "R11 register", int'(d), 0);
    end
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, d); chk(d == 32'h7F,  "R2 control", int'(d), 'h7F);
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, d); chk(d == 32'h7FF, "R2 duty",    int'(d), 'h7FF);
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, d); chk(d == 32'h3FF, "R2 period",  int'(d), 'h3FF);
    rd(5'h10, d); chk(d == 0, "R1 channel 1 untouched", int'(d), 0);
    wr(5'h00, 0); wr(5'h04, 0); wr(5'h08, 0);
    wr(5'h0C, 32'hFFFF_FFFF); wr(5'h02, 32'hFFFF_FFFF); wr(5'h16, 32'hFFFF_FFFF);
    rd(5'h0C, d); chk(d == 0, "R2 undefined read", int'(d), 0);
    rd(5'h00, d); chk(d == 0, "R1 misaligned write ignored", int'(d), 0);
    rd(5'h14, d); chk(d == 0, "R1 misaligned ch1 write ignored", int'(d), 0);
  endtask

  // program a channel, run whole periods, compare each clock with the ideal wave
  task automatic t_wave(input int ch, input int pre, input int pv, input int dc,
                        input bit full, input int periods, input string tag);
    int per = (pre + 1) * (pv + 1);
    int mism = 0, highs = 0, other = 0, onLen, expHigh;
    logic [4:0] base = 5'(ch * 16);
    wr(base + 5'h0, 32'(pre));
    wr(base + 5'h4, 32'(dc) | (full ? 32'h400 : 32'h0));
    wr(base + 5'h8, 32'(pv));
    chanEn[ch] = 1'b1;
    for (int k = 0; k < periods * per; k++) begin
      @(negedge clk);
      expHigh = (full || ((k % per) / (pre + 1)) < dc) ? 1 : 0;
      if (int'(pwmOut[ch]) != expHigh) mism++;
      if (pwmOut[ch]) highs++;
      if (pwmOut[1-ch]) other++;
    end
    chanEn[ch] = 1'b0;
    repeat (per + 2) @(negedge clk);
    onLen = full ? pv + 1 : (dc < pv + 1 ? dc : pv + 1);
    chk(mism == 0, {tag, " waveform shape"}, mism, 0);
    chk(highs == periods * (pre + 1) * onLen, {tag, " active clocks"}, highs, periods * (pre + 1) * onLen);
    chk(other == 0, "R12 other channel quiet", other, 0);
  endtask

  task automatic count(input int ch, input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwmOut[ch]) h++;
    end
  endtask

  task automatic t_shadow();
    int h;
    wr(5'h00, 0); wr(5'h04, 2); wr(5'h08, 9);
    chanEn[0] = 1'b1;
    count(0, 3, h);
    wr(5'h04, 7);             // mid-period update
    count(0, 6, h);
    chk(h == 0, "R10 current period unchanged", h, 0);
    count(0, 10, h);
    chk(h == 7, "R10 new duty next period", h, 7);
    chanEn[0] = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_abrupt();
    int h;
    wr(5'h00, 32'h40); wr(5'h04, 32'h400); wr(5'h08, 9);
    chanEn[0] = 1'b1;
    count(0, 4, h);
    chk(h == 4, "R7 full flag active", h, 4);
    chanEn[0] = 1'b0;
    count(0, 1, h);
    chk(h == 0, "R8 halts at next clock", h, 0);
    count(0, 10, h);
    chk(h == 0, "R8 stays inactive", h, 0);
  endtask

  task automatic t_graceful();
    int h;
    wr(5'h00, 0); wr(5'h04, 32'h400); wr(5'h08, 9);
    chanEn[0] = 1'b1;
    count(0, 4, h);
    chanEn[0] = 1'b0;
    count(0, 6, h);
    chk(h == 6, "R9 period completes", h, 6);
    count(0, 10, h);
    chk(h == 0, "R9 inactive after period", h, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_wave(0, 0, 9, 3, 1'b0, 3, "R4");
    t_wave(0, 2, 4, 2, 1'b0, 2, "R3");
    t_wave(0, 1, 5, 0, 1'b0, 2, "R5");
    t_wave(0, 0, 9, 12, 1'b0, 2, "R6");
    t_wave(0, 0, 9, 0, 1'b1, 2, "R7");
    t_wave(1, 1, 7, 5, 1'b0, 2, "R12");
    t_shadow();
    t_abrupt();
    t_graceful();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule